// File: doc/BRIEF.md
# Two-Processor Mailbox Flag Controller

This block lets two processors signal each other over a set of mailbox channels, one flag per channel and per direction. A processor raises one of its own channel flags to say "message posted"; the other processor sees the flag, takes a receive interrupt, and acknowledges by clearing that flag. Once the flag is clear again, the sender takes a "channel free" interrupt and may post on that channel again. The block holds only the flags and interrupt controls. Message payloads live elsewhere.

Each processor has its own simple register port and its own register bank. A bank holds an enable word, a mask word, a write-one set/clear word and a status word. Either port may read any bank, so a processor can look at the flags its peer has raised. A port may write only its own bank. Each processor drives two level interrupts, one for receive and one for transmit-free. They are computed combinationally from registered state. A shared configuration word reports the channel count, and a version word reports the revision.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, every flag, enable and mask is 0, every register reads 0 except the configuration and version words, and all four interrupt outputs are low.
- R2: The bank of processor p starts at byte address p*0x10. Within a bank, 0x0 is the enable word, 0x4 the mask word, 0x8 the set/clear word and 0xC the status word. Either port can read either bank. A write from port p reaches only bank p, and a write from port p to the other bank changes nothing.
- R3: In the enable word, bit 0 enables the receive interrupt and bit 16 enables the transmit-free interrupt. Both bits read back as written.
- R4: In the mask word, bit n is the receive mask of channel n and bit 16+n is the transmit-free mask of channel n. Both halves read back as written.
- R5: When processor p writes 1 to set/clear bit 16+n, its own flag n is set. The status word of bank p shows processor p's flags in bits N-1:0.
- R6: When processor p writes 1 to set/clear bit n, the peer's flag n is cleared. Writing 0 to any set/clear bit has no effect, and the set/clear word always reads 0.
- R7: If one processor sets a flag and the other clears the same flag in the same cycle, the flag ends up set.
- R8: The receive interrupt of processor p is high when its receive enable is 1 and some peer flag n is 1 while receive mask bit n of p is 0. Otherwise it is low.
- R9: The transmit interrupt of processor p is high when its transmit enable is 1 and some own flag n is 0 while transmit mask bit n of p is 0. Otherwise it is low.
- R10: The word at 0x3F0 reads the channel count N in bits 7:0. The word at 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0. Any other address reads 0.
- R11: Mask, status and set/clear bits that belong to channels at or above N read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_sel | input | 1 | Port 0 access strobe |
| p0_wr | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | 10 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 read data, combinational |
| p1_sel | input | 1 | Port 1 access strobe |
| p1_wr | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | 10 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 read data, combinational |
| p0_rx_irq | output | 1 | Processor 0 receive interrupt |
| p0_tx_irq | output | 1 | Processor 0 transmit-free interrupt |
| p1_rx_irq | output | 1 | Processor 1 receive interrupt |
| p1_tx_irq | output | 1 | Processor 1 transmit-free interrupt |

## Verification
The hardest case to reach is a set and a clear of the same flag in the same clock cycle. The set comes from the flag's owner and the clear from its peer, so the two requests arrive on different ports. The bench drives both ports in the same cycle and then reads the status word back. The interrupt equations are covered by a sweep over every pairing of flag pattern and mask pattern in a four-channel build, and the expected interrupt levels are computed arithmetically in the bench.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned HALF    = 16;
  localparam int unsigned NPROC   = 2;
  localparam logic [1:0]  OFF_EN  = 2'd0;
  localparam logic [1:0]  OFF_MSK = 2'd1;
  localparam logic [1:0]  OFF_SC  = 2'd2;
  localparam logic [1:0]  OFF_ST  = 2'd3;
  localparam logic [7:0]  CFG_WORD = 8'hFC;
  localparam logic [7:0]  VER_WORD = 8'hFD;
endpackage

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              rx_en,
  output logic              tx_en,
  output logic [N-1:0]      rx_mask,
  output logic [N-1:0]      tx_mask,
  output logic [N-1:0]      set_req,
  output logic [N-1:0]      clr_req
);
  logic          en_we, msk_we, sc_we;
  logic          rx_en_d, tx_en_d;
  logic [N-1:0]  rx_mask_d, tx_mask_d;

  always_comb begin
    en_we     = wr_en && (reg_sel == OFF_EN);
    msk_we    = wr_en && (reg_sel == OFF_MSK);
    sc_we     = wr_en && (reg_sel == OFF_SC);
    rx_en_d   = wdata[0];
    tx_en_d   = wdata[HALF];
    rx_mask_d = wdata[N-1:0];
    tx_mask_d = wdata[HALF +: N];
    set_req   = sc_we ? wdata[HALF +: N] : '0;
    clr_req   = sc_we ? wdata[N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (en_we) begin
      rx_en <= rx_en_d;
      tx_en <= tx_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mask <= '0;
      tx_mask <= '0;
    end else if (msk_we) begin
      rx_mask <= rx_mask_d;
      tx_mask <= tx_mask_d;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !msk_we |=> ($stable(rx_mask) && $stable(tx_mask))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> ($stable(rx_en) && $stable(tx_en))); // R3
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_d;
  logic         upd;

  always_comb begin
    upd    = |(set_req | clr_req);
    flag_d = (flag & ~clr_req) | set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= '0;
    else if (upd) flag <= flag_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_req) |=> ((flag & $past(set_req)) == $past(set_req))); // R7
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_req & ~set_req)) |=> ((flag & $past(clr_req & ~set_req)) == '0)); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req == '0 && clr_req == '0) |=> $stable(flag)); // R5
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         tx_en,
  input  logic [N-1:0] rx_mask,
  input  logic [N-1:0] tx_mask,
  input  logic [N-1:0] own_flag,
  input  logic [N-1:0] peer_flag,
  output logic         rx_irq,
  output logic         tx_irq
);
  logic [N-1:0] rx_pend, tx_pend;

  always_comb begin
    rx_pend = peer_flag & ~rx_mask;
    tx_pend = ~own_flag & ~tx_mask;
    rx_irq  = rx_en && (|rx_pend);
    tx_irq  = tx_en && (|tx_pend);
  end

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_irq); // R8
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_irq); // R9
  AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mask == '1) |-> !rx_irq); // R8
endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned N         = 16,
  parameter logic [3:0]  VER_MAJOR = 4'd2,
  parameter logic [3:0]  VER_MINOR = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_sel,
  input  logic              p0_wr,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_sel,
  input  logic              p1_wr,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic [DATA_W-1:0] p1_rdata,
  output logic              p0_rx_irq,
  output logic              p0_tx_irq,
  output logic              p1_rx_irq,
  output logic              p1_tx_irq
);
  logic              rst_q1, rst_q2;
  logic [NPROC-1:0]  sel_a, wr_a, wr_hit, rx_en, tx_en, rx_irq, tx_irq;
  logic [ADDR_W-1:0] addr_a  [NPROC];
  logic [DATA_W-1:0] wdata_a [NPROC];
  logic [DATA_W-1:0] rdata_a [NPROC];
  logic [N-1:0]      rx_mask [NPROC];
  logic [N-1:0]      tx_mask [NPROC];
  logic [N-1:0]      set_req [NPROC];
  logic [N-1:0]      clr_req [NPROC];
  logic [N-1:0]      flag    [NPROC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  always_comb begin
    sel_a      = {p1_sel, p0_sel};
    wr_a       = {p1_wr, p0_wr};
    addr_a[0]  = p0_addr;
    addr_a[1]  = p1_addr;
    wdata_a[0] = p0_wdata;
    wdata_a[1] = p1_wdata;
    p0_rdata   = rdata_a[0];
    p1_rdata   = rdata_a[1];
    p0_rx_irq  = rx_irq[0];
    p0_tx_irq  = tx_irq[0];
    p1_rx_irq  = rx_irq[1];
    p1_tx_irq  = tx_irq[1];
  end

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    localparam int unsigned PEER = NPROC - 1 - p;
    logic       bank_b;
    logic [1:0] word_off;
    logic       in_banks;

    always_comb begin
      in_banks  = (addr_a[p][ADDR_W-1:5] == '0) && (addr_a[p][1:0] == 2'b00);
      bank_b    = addr_a[p][4];
      word_off  = addr_a[p][3:2];
      wr_hit[p] = sel_a[p] && wr_a[p] && in_banks && (bank_b == p[0]);
    end

    always_comb begin
      rdata_a[p] = '0;
      if (sel_a[p] && !wr_a[p]) begin
        if (in_banks) begin
          case (word_off)
            OFF_EN: begin
              rdata_a[p][0]    = rx_en[bank_b];
              rdata_a[p][HALF] = tx_en[bank_b];
            end
            OFF_MSK: begin
              rdata_a[p][N-1:0]     = rx_mask[bank_b];
              rdata_a[p][HALF +: N] = tx_mask[bank_b];
            end
            OFF_ST:  rdata_a[p][N-1:0] = flag[bank_b];
            default: rdata_a[p] = '0;
          endcase
        end else if (addr_a[p][ADDR_W-1:2] == CFG_WORD && addr_a[p][1:0] == 2'b00) begin
          rdata_a[p][7:0] = 8'(N);
        end else if (addr_a[p][ADDR_W-1:2] == VER_WORD && addr_a[p][1:0] == 2'b00) begin
          rdata_a[p][7:0] = {VER_MAJOR, VER_MINOR};
        end
      end
    end

    mbox_bank #(.N(N)) u_bank (
      .clk(clk), .rst_n(rst_q2), .wr_en(wr_hit[p]), .reg_sel(word_off),
      .wdata(wdata_a[p]), .rx_en(rx_en[p]), .tx_en(tx_en[p]),
      .rx_mask(rx_mask[p]), .tx_mask(tx_mask[p]),
      .set_req(set_req[p]), .clr_req(clr_req[p])
    );

    mbox_flags #(.N(N)) u_flags (
      .clk(clk), .rst_n(rst_q2), .set_req(set_req[p]),
      .clr_req(clr_req[PEER]), .flag(flag[p])
    );

    mbox_irq #(.N(N)) u_irq (
      .clk(clk), .rst_n(rst_q2), .rx_en(rx_en[p]), .tx_en(tx_en[p]),
      .rx_mask(rx_mask[p]), .tx_mask(tx_mask[p]),
      .own_flag(flag[p]), .peer_flag(flag[PEER]),
      .rx_irq(rx_irq[p]), .tx_irq(tx_irq[p])
    );

    AST_SC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_q2)
      (sel_a[p] && !wr_a[p] && in_banks && word_off == OFF_SC) |-> (rdata_a[p] == '0)); // R6
    AST_FOREIGN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_q2)
      (sel_a[p] && wr_a[p] && in_banks && bank_b != p[0]) |-> !wr_hit[p]); // R2
  end
endmodule

// File: tb/mbox_flag_ctrl_test.sv
module mbox_flag_ctrl_test;
  localparam int NCH = 4;
  localparam logic [31:0] CMASK = (32'd1 << NCH) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0_sel = 0, p0_wr = 0, p1_sel = 0, p1_wr = 0;
  logic [9:0]  p0_addr = '0, p1_addr = '0;
  logic [31:0] p0_wdata = '0, p1_wdata = '0;
  logic [31:0] p0_rdata, p1_rdata;
  logic p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_flag_ctrl #(.N(NCH), .VER_MAJOR(4'd2), .VER_MINOR(4'd1)) uut (
    .clk(clk), .rst_n(rst_n),
    .p0_sel(p0_sel), .p0_wr(p0_wr), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_sel(p1_sel), .p1_wr(p1_wr), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .p0_rx_irq(p0_rx_irq), .p0_tx_irq(p0_tx_irq), .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    if (p == 0) begin p0_sel = 1; p0_wr = 1; p0_addr = a; p0_wdata = d; end
    else        begin p1_sel = 1; p1_wr = 1; p1_addr = a; p1_wdata = d; end
    @(negedge clk);
    p0_sel = 0; p0_wr = 0; p1_sel = 0; p1_wr = 0;
  endtask

  task automatic rd(input int p, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    if (p == 0) begin p0_sel = 1; p0_wr = 0; p0_addr = a; end
    else        begin p1_sel = 1; p1_wr = 0; p1_addr = a; end
    #1;
    d = (p == 0) ? p0_rdata : p1_rdata;
    p0_sel = 0; p1_sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 8; a++) begin
        rd(p, 10'(a * 4), v);
        chk("R1 reset reg", v, 32'h0);
      end
    chk("R1 irqs", {28'h0, p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq}, 32'h0);

    // R10 cfg, version, unmapped
    rd(0, 10'h3F0, v); chk("R10 cfg", v, NCH);
    rd(1, 10'h3F4, v); chk("R10 ver", v, 32'h21);
    rd(0, 10'h200, v); chk("R10 unmapped", v, 32'h0);

    // R3 R11 enable and mask layout, unimplemented bits
    wr(0, 10'h000, 32'hFFFF_FFFF);
    rd(1, 10'h000, v); chk("R3 enable readback", v, 32'h0001_0001);
    wr(0, 10'h000, 32'h0);
    wr(1, 10'h014, 32'hFFFF_FFFF);
    rd(0, 10'h014, v); chk("R4 R11 mask readback", v, (CMASK << 16) | CMASK);
    wr(1, 10'h014, 32'h0005_000A);
    rd(1, 10'h014, v); chk("R4 mask halves", v, 32'h0005_000A);
    wr(1, 10'h014, 32'h0);

    // R2 foreign-bank writes ignored
    wr(1, 10'h004, 32'hFFFF_FFFF);
    rd(0, 10'h004, v); chk("R2 foreign mask write", v, 32'h0);
    wr(0, 10'h018, 32'h000F_0000);
    rd(1, 10'h01C, v); chk("R2 foreign set write", v, 32'h0);

    // R5 R6 per-channel set and clear both directions
    for (int p = 0; p < 2; p++)
      for (int ch = 0; ch < NCH; ch++) begin
        wr(p, 10'(p * 16 + 8), 32'h1 << (16 + ch));
        rd(1 - p, 10'(p * 16 + 12), v); chk("R5 status set", v, 32'h1 << ch);
        rd(p, 10'(p * 16 + 8), v); chk("R6 setclr reads 0", v, 32'h0);
        wr(p, 10'(p * 16 + 8), 32'h0);
        wr(1 - p, 10'((1 - p) * 16 + 8), 32'h0);
        rd(p, 10'(p * 16 + 12), v); chk("R6 zero write no effect", v, 32'h1 << ch);
        wr(1 - p, 10'((1 - p) * 16 + 8), 32'h1 << ch);
        rd(p, 10'(p * 16 + 12), v); chk("R6 status cleared", v, 32'h0);
      end

    // R11 set beyond N
    wr(0, 10'h008, 32'hFFFF_0000);
    rd(0, 10'h00C, v); chk("R11 status width", v, CMASK);
    wr(1, 10'h018, 32'h0000_FFFF);
    rd(0, 10'h00C, v); chk("R11 clear all", v, 32'h0);

    // R7 same-cycle set and clear
    @(negedge clk);
    p0_sel = 1; p0_wr = 1; p0_addr = 10'h008; p0_wdata = 32'h1 << 18;
    p1_sel = 1; p1_wr = 1; p1_addr = 10'h018; p1_wdata = 32'h1 << 2;
    @(negedge clk);
    p0_sel = 0; p0_wr = 0; p1_sel = 0; p1_wr = 0;
    rd(1, 10'h00C, v); chk("R7 set wins", v, 32'h4);
    wr(1, 10'h018, 32'h4);

    // R8 R9 gating off
    wr(0, 10'h008, 32'h0001_0000);
    chk("R8 rx disabled", {31'h0, p1_rx_irq}, 32'h0);
    chk("R9 tx disabled", {31'h0, p1_tx_irq}, 32'h0);

    // R8 R9 sweep: proc0 flags f, masks m; proc1 rx, proc0 tx
    wr(1, 10'h010, 32'h0000_0001);
    wr(0, 10'h000, 32'h0001_0000);
    for (int f = 0; f < 16; f++)
      for (int m = 0; m < 16; m++) begin
        wr(1, 10'h018, CMASK);
        wr(0, 10'h008, 32'(f) << 16);
        wr(1, 10'h014, 32'(m));
        wr(0, 10'h004, 32'(m) << 16);
        chk("R8 rx sweep", {31'h0, p1_rx_irq}, {31'h0, |(4'(f) & ~4'(m))});
        chk("R9 tx sweep", {31'h0, p0_tx_irq}, {31'h0, |(~4'(f) & ~4'(m))});
      end
    wr(0, 10'h004, 32'h0);
    wr(1, 10'h018, CMASK);

    // R8 R9 other direction
    wr(0, 10'h000, 32'h0000_0001);
    wr(1, 10'h010, 32'h0001_0000);
    for (int f = 0; f < 16; f++) begin
      wr(0, 10'h008, CMASK);
      wr(1, 10'h018, 32'(f) << 16);
      chk("R8 rx p0", {31'h0, p0_rx_irq}, {31'h0, f != 0});
      chk("R9 tx p1", {31'h0, p1_tx_irq}, {31'h0, f != 15});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule